// File: doc/BRIEF.md
# Quasi-Bidirectional Port Slice with Alternate Functions

This block is one eight-bit general-purpose I/O port of a small microcontroller. Each bit has an output latch written by the core. A read returns either the latch contents or the external pin level, selected per access. The read-latch path serves read-modify-write instructions, and the read-pin path serves plain input reads. The pin drive is modelled with three controls per bit: a strong drive enable, a drive value and a weak pull-up. With these controls the surrounding pad logic can build a quasi-bidirectional pin or an open-drain pin. A latch value of 0 pulls the pin strongly low. A latch value of 1 releases it to a weak pull-up, or to high impedance in the open-drain variant, so software writes 1 to a bit before it uses that bit as an input.

A peripheral can take over any bit through an alternate-function select. Its output reaches the pin only while the latch bit holds 1. A latch value of 0 blocks it and holds the pin low. The port can also serve as a multiplexed external bus. An access request is accepted through a valid/ready handshake. The port then drives the low address byte for one cycle while the address strobe is high. In the next cycle it either drives write data or releases the pins and samples read data. Each access ends with a single-cycle response pulse. An access overwrites the latch with all ones, so the previous latch contents are lost.

The request channel applies back-pressure: a request is taken on a cycle where both `bus_req_valid` and `bus_req_ready` are high. Ready is low for the two access cycles. The requester must hold its valid signal and its fields stable until the request is taken. The response channel has no back-pressure. `bus_rsp_valid` is high for exactly one cycle, and the consumer must take the response in that cycle.

Top module: `qb_port`

## Requirements
- R1: While reset is asserted and right after it is released, every latch bit reads 1, `bus_req_ready` is 1, `ale` is 0, and every pin is released (`pin_oe` all 0).
- R2: A software write (`wr_en`=1) loads `wr_data` into the latch at the clock edge. With `rd_from_pin`=0, `rd_data` shows the latch contents.
- R3: With `rd_from_pin`=1, `rd_data` shows `pin_in` whatever the latch holds.
- R4: Outside a bus access, a bit whose latch holds 0 is driven strongly low: `pin_oe`=1, `pin_out`=0 and `pin_pullup`=0.
- R5: In the quasi-bidirectional variant (`OPEN_DRAIN`=0), outside a bus access, a bit whose latch holds 1 and is not driven low by its alternate function has `pin_oe`=0 and `pin_pullup`=1.
- R6: In the open-drain variant (`OPEN_DRAIN`=1), `pin_pullup` is always 0, and a bit released by its latch has `pin_oe`=0.
- R7: A bit with `alt_en`=1 follows `alt_out` (0 gives a strong low, 1 releases the pin) only while its latch bit is 1. While the latch bit is 0, the pin is held low whatever `alt_out` is.
- R8: A bus request is taken when `bus_req_valid` and `bus_req_ready` are both 1. `bus_req_ready` is then 0 for the next two cycles and returns to 1 in the third.
- R9: In the cycle after a request is taken (the address phase), `ale`=1 and every pin is strongly driven (`pin_oe` all 1) with `bus_req_addr`, whatever the latch and alternate selects hold.
- R10: In the second cycle of a write access (`bus_req_write`=1), `ale`=0 and every pin is strongly driven with `bus_req_wdata`.
- R11: In the second cycle of a read access, every pin is released (`pin_oe`=0 and `pin_pullup`=0). The value of `pin_in` in that cycle is returned on `bus_rsp_rdata` in the next cycle, together with a single-cycle `bus_rsp_valid`. A write access also pulses `bus_rsp_valid`, with `bus_rsp_rdata`=0.
- R12: After any bus access the latch holds all ones. This restore takes priority over a software write made in the last access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software latch write strobe |
| wr_data | input | WIDTH | Value to write to the latch |
| rd_from_pin | input | 1 | Read source: 1 = pin level, 0 = latch contents |
| rd_data | output | WIDTH | Read result |
| alt_en | input | WIDTH | Per-bit alternate-function select |
| alt_out | input | WIDTH | Per-bit alternate-function output value |
| pin_in | input | WIDTH | Sampled external pin level |
| pin_oe | output | WIDTH | Strong drive enable per pin |
| pin_out | output | WIDTH | Drive value per pin when `pin_oe` is 1 |
| pin_pullup | output | WIDTH | Weak pull-up enable per pin |
| ale | output | 1 | Address strobe, high during the address phase |
| bus_req_valid | input | 1 | Bus access request valid |
| bus_req_ready | output | 1 | Port idle and able to take a request |
| bus_req_write | input | 1 | 1 = write access, 0 = read access |
| bus_req_addr | input | WIDTH | Low address byte of the access |
| bus_req_wdata | input | WIDTH | Write data of the access |
| bus_rsp_valid | output | 1 | Single-cycle access-complete pulse |
| bus_rsp_rdata | output | WIDTH | Read data, valid with `bus_rsp_valid` |

## Verification
The bench builds two copies of the port at the default width of eight bits and drives both from the same inputs. One copy is quasi-bidirectional and the other is open-drain. This makes the weak-pull-up and the high-impedance release of a latch value of 1 directly comparable for the same latch patterns. Both copies also see the same bus traffic, so the open-drain copy is checked for the absence of any pull-up through the address and data phases as well as at rest. The chosen latch, alternate-select and alternate-output patterns mix all four combinations of latch and alternate value in one byte. One read access has a software write in its final cycle, which exercises the priority of the restore over that write.

// File: rtl/qb_port_pkg.sv
package qb_port_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } bus_phase_e;
endpackage

// File: rtl/qb_latch.sv
module qb_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             restore,
  output logic [WIDTH-1:0] latch_q
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  // The restore at the end of a bus access wins over a software write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latch_q <= ALL_ONES;
    else if (restore) latch_q <= ALL_ONES;
    else if (wr_en)   latch_q <= wr_data;
  end

  assert_restore_ones_R12: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> latch_q == ALL_ONES);

  assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !restore) |=> latch_q == $past(wr_data));
endmodule

// File: rtl/qb_bus_seq.sv
module qb_bus_seq
  import qb_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [WIDTH-1:0] req_addr,
  input  logic [WIDTH-1:0] req_wdata,
  input  logic [WIDTH-1:0] pin_in,
  output bus_phase_e       phase,
  output logic             cur_write,
  output logic [WIDTH-1:0] cur_addr,
  output logic [WIDTH-1:0] cur_wdata,
  output logic             restore,
  output logic             rsp_valid,
  output logic [WIDTH-1:0] rsp_rdata
);
  bus_phase_e phase_q;
  logic       take;

  assign req_ready = (phase_q == PH_IDLE);
  assign take      = req_valid && req_ready;
  assign phase     = phase_q;
  assign restore   = (phase_q == PH_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cur_write <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (take) begin
          phase_q   <= PH_ADDR;
          cur_write <= req_write;
          cur_addr  <= req_addr;
          cur_wdata <= req_wdata;
        end
        PH_ADDR: phase_q <= PH_DATA;
        PH_DATA: begin
          phase_q   <= PH_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= cur_write ? '0 : pin_in;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assert_take_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req_ready);

  assert_busy_two_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ADDR) |=> !req_ready);

  assert_rsp_after_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(phase_q == PH_DATA) && req_ready);
endmodule

// File: rtl/qb_pin_drv.sv
module qb_pin_drv
  import qb_port_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter bit OPEN_DRAIN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] alt_en,
  input  logic [WIDTH-1:0] alt_out,
  input  bus_phase_e       phase,
  input  logic             cur_write,
  input  logic [WIDTH-1:0] cur_addr,
  input  logic [WIDTH-1:0] cur_wdata,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_pullup,
  output logic             ale
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  assign ale = (phase == PH_ADDR);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic release_hi;
    // The latch gates the alternate output: a 0 in the latch forces low.
    assign release_hi = latch_q[b] & (alt_en[b] ? alt_out[b] : 1'b1);

    always_comb begin
      unique case (phase)
        PH_ADDR: begin
          pin_oe[b]     = 1'b1;
          pin_out[b]    = cur_addr[b];
          pin_pullup[b] = 1'b0;
        end
        PH_DATA: begin
          pin_oe[b]     = cur_write;
          pin_out[b]    = cur_write & cur_wdata[b];
          pin_pullup[b] = 1'b0;
        end
        default: begin
          pin_oe[b]     = ~release_hi;
          pin_out[b]    = 1'b0;
          pin_pullup[b] = release_hi & ~OPEN_DRAIN;
        end
      endcase
    end
  end

  if (OPEN_DRAIN) begin : g_od_check
    assert_no_pullup_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pin_pullup == '0);
  end

  assert_latch0_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> ((pin_oe | latch_q) == ALL_ONES) && ((pin_out & ~latch_q) == '0));

  assert_addr_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (pin_oe == ALL_ONES) && (pin_out == cur_addr));

  assert_read_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && !cur_write) |-> (pin_oe == '0) && (pin_pullup == '0));
endmodule

// File: rtl/qb_port.sv
module qb_port
  import qb_port_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter bit OPEN_DRAIN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_from_pin,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] alt_en,
  input  logic [WIDTH-1:0] alt_out,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_pullup,
  output logic             ale,
  input  logic             bus_req_valid,
  output logic             bus_req_ready,
  input  logic             bus_req_write,
  input  logic [WIDTH-1:0] bus_req_addr,
  input  logic [WIDTH-1:0] bus_req_wdata,
  output logic             bus_rsp_valid,
  output logic [WIDTH-1:0] bus_rsp_rdata
);
  logic [WIDTH-1:0] latch_q;
  logic             restore;
  bus_phase_e       phase;
  logic             cur_write;
  logic [WIDTH-1:0] cur_addr;
  logic [WIDTH-1:0] cur_wdata;

  assign rd_data = rd_from_pin ? pin_in : latch_q;

  qb_latch #(.WIDTH(WIDTH)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .restore (restore),
    .latch_q (latch_q)
  );

  qb_bus_seq #(.WIDTH(WIDTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (bus_req_valid),
    .req_ready (bus_req_ready),
    .req_write (bus_req_write),
    .req_addr  (bus_req_addr),
    .req_wdata (bus_req_wdata),
    .pin_in    (pin_in),
    .phase     (phase),
    .cur_write (cur_write),
    .cur_addr  (cur_addr),
    .cur_wdata (cur_wdata),
    .restore   (restore),
    .rsp_valid (bus_rsp_valid),
    .rsp_rdata (bus_rsp_rdata)
  );

  qb_pin_drv #(.WIDTH(WIDTH), .OPEN_DRAIN(OPEN_DRAIN)) u_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch_q    (latch_q),
    .alt_en     (alt_en),
    .alt_out    (alt_out),
    .phase      (phase),
    .cur_write  (cur_write),
    .cur_addr   (cur_addr),
    .cur_wdata  (cur_wdata),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out),
    .pin_pullup (pin_pullup),
    .ale        (ale)
  );
endmodule

// File: tb/test_qb_port.sv
`timescale 1ns/1ps
module test_qb_port;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic rd_from_pin = 1'b0;
  logic [W-1:0] alt_en = '0;
  logic [W-1:0] alt_out = '0;
  logic [W-1:0] pin_in = '0;
  logic bus_req_valid = 1'b0;
  logic bus_req_write = 1'b0;
  logic [W-1:0] bus_req_addr = '0;
  logic [W-1:0] bus_req_wdata = '0;

  logic [W-1:0] rd_data, pin_oe, pin_out, pin_pullup, bus_rsp_rdata;
  logic ale, bus_req_ready, bus_rsp_valid;
  logic [W-1:0] od_rd_data, od_oe, od_out, od_pu, od_rdata;
  logic od_ale, od_ready, od_rsp;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  qb_port #(.WIDTH(W), .OPEN_DRAIN(1'b0)) i_qb_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_from_pin(rd_from_pin), .rd_data(rd_data), .alt_en(alt_en), .alt_out(alt_out),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pullup(pin_pullup),
    .ale(ale), .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
    .bus_req_wdata(bus_req_wdata), .bus_rsp_valid(bus_rsp_valid),
    .bus_rsp_rdata(bus_rsp_rdata)
  );

  qb_port #(.WIDTH(W), .OPEN_DRAIN(1'b1)) i_qb_port_od (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_from_pin(rd_from_pin), .rd_data(od_rd_data), .alt_en(alt_en), .alt_out(alt_out),
    .pin_in(pin_in), .pin_oe(od_oe), .pin_out(od_out), .pin_pullup(od_pu),
    .ale(od_ale), .bus_req_valid(bus_req_valid), .bus_req_ready(od_ready),
    .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
    .bus_req_wdata(bus_req_wdata), .bus_rsp_valid(od_rsp),
    .bus_rsp_rdata(od_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive on the falling edge, let one rising edge pass, sample on the next falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sw_write(input logic [W-1:0] v);
    wr_en = 1'b1; wr_data = v;
    step();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rd_from_pin = 1'b0;
    check("R1 latch during reset", rd_data, 8'hFF);
    check("R1 ready during reset", bus_req_ready, 1);
    rst_n = 1'b1;
    step();
    check("R1 latch after reset", rd_data, 8'hFF);
    check("R1 ale", ale, 0);
    check("R1 pins released", pin_oe, 8'h00);
    check("R5 pullup after reset", pin_pullup, 8'hFF);
  endtask

  task automatic t_write_read();
    sw_write(8'h5A);
    rd_from_pin = 1'b0;
    #0.1;
    check("R2 read latch", rd_data, 8'h5A);
    sw_write(8'hC9);
    check("R2 read latch second", rd_data, 8'hC9);
    sw_write(8'h5A);
  endtask

  task automatic t_pin_read();
    pin_in = 8'hC3;
    rd_from_pin = 1'b1;
    #0.1;
    check("R3 read pin", rd_data, 8'hC3);
    rd_from_pin = 1'b0;
    #0.1;
    check("R3 latch unchanged by pin", rd_data, 8'h5A);
  endtask

  task automatic t_drive();
    // Latch 5A: zero bits are A5.
    check("R4 strong low oe", pin_oe, 8'hA5);
    check("R4 drive value", pin_out, 8'h00);
    check("R5 weak pullup on ones", pin_pullup, 8'h5A);
    check("R6 open-drain oe", od_oe, 8'hA5);
    check("R6 open-drain no pullup", od_pu, 8'h00);
  endtask

  task automatic t_alt();
    sw_write(8'hF0);
    alt_en = 8'hCC;
    alt_out = 8'hA5;
    #0.1;
    check("R7 alt gated oe", pin_oe, 8'h4F);
    check("R7 alt gated pullup", pin_pullup, 8'hB0);
    alt_out = 8'hFF;
    #0.1;
    check("R7 latch zero blocks alt", pin_oe, 8'h0F);
    alt_en = 8'h00;
    alt_out = 8'h00;
  endtask

  task automatic t_bus_write();
    sw_write(8'h5A);
    alt_en = 8'hFF;
    check("R8 ready idle", bus_req_ready, 1);
    bus_req_valid = 1'b1; bus_req_write = 1'b1;
    bus_req_addr = 8'h34; bus_req_wdata = 8'h9E;
    step();
    bus_req_valid = 1'b0;
    check("R9 ale high", ale, 1);
    check("R9 addr oe", pin_oe, 8'hFF);
    check("R9 addr value", pin_out, 8'h34);
    check("R8 ready low addr", bus_req_ready, 0);
    check("R6 open-drain no pullup in bus", od_pu, 8'h00);
    step();
    check("R10 ale low", ale, 0);
    check("R10 data oe", pin_oe, 8'hFF);
    check("R10 data value", pin_out, 8'h9E);
    check("R8 ready low data", bus_req_ready, 0);
    step();
    check("R11 write rsp valid", bus_rsp_valid, 1);
    check("R11 write rsp data", bus_rsp_rdata, 8'h00);
    check("R8 ready back", bus_req_ready, 1);
    check("R12 latch ones after write", rd_data, 8'hFF);
    step();
    check("R11 rsp single cycle", bus_rsp_valid, 0);
    alt_en = 8'h00;
  endtask

  task automatic t_bus_read();
    sw_write(8'h0F);
    bus_req_valid = 1'b1; bus_req_write = 1'b0;
    bus_req_addr = 8'h71; bus_req_wdata = 8'h00;
    step();
    bus_req_valid = 1'b0;
    check("R9 read addr value", pin_out, 8'h71);
    check("R9 read ale", ale, 1);
    step();
    check("R11 read release oe", pin_oe, 8'h00);
    check("R11 read release pullup", pin_pullup, 8'h00);
    pin_in = 8'h6D;
    wr_en = 1'b1; wr_data = 8'h00;
    step();
    wr_en = 1'b0;
    check("R11 read rsp valid", bus_rsp_valid, 1);
    check("R11 read data", bus_rsp_rdata, 8'h6D);
    check("R12 restore beats write", rd_data, 8'hFF);
    check("R5 pins weak high after access", pin_pullup, 8'hFF);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_write_read();
    t_pin_read();
    t_drive();
    t_alt();
    t_bus_write();
    t_bus_read();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule